// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block decides, for each transaction on an I2C bus, whether the local controller is being addressed as a target. A byte engine that handles bus timing hands it the bytes that follow a START or repeated START. Each byte comes with a strobe and a flag that says whether it is the first or the second byte after that condition. One clock later the recognizer answers with an ACK or NACK decision. When an address has been fully recognized, it also raises a single-cycle match pulse together with the transfer direction, a general-call flag and the address that matched.

Configuration inputs select the own address, 7-bit or 10-bit addressing, general-call recognition and recognition of the reserved SMBus addresses. A 10-bit address takes two bytes. A later repeated START that carries only the read header is accepted only if the full 10-bit address was already recognized in the same transaction. After a NACK, or after a completed match, the recognizer ignores every byte until the next START.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, ackValid, ackYes, matchPulse, dirRead and genCall are 0 and matchedAddr is 0. Bytes presented before the first START get no response.
- R2: In 7-bit mode, a first byte (byteSecond=0) whose bits 7:1 equal cfgOwnAddr[6:0] produces, on the clock after the byte strobe, ackValid=1, ackYes=1 and matchPulse=1. It also sets dirRead to byte bit 0 and matchedAddr to {3'b000, cfgOwnAddr[6:0]}.
- R3: A first byte that matches nothing gets ackValid=1 with ackYes=0. Every later byte gets no response until the next START.
- R4: In 10-bit mode, the write header 11110 cfgOwnAddr[9:8] 0 gets ACK without a match pulse. A following second byte (byteSecond=1) equal to cfgOwnAddr[7:0] gets ACK and a match pulse, with dirRead=0 and matchedAddr=cfgOwnAddr.
- R5: In 10-bit mode the following get NACK and start the ignore state: a header with other address bits 9:8, a second byte that differs from cfgOwnAddr[7:0], and a 7-bit style byte equal to {cfgOwnAddr[6:0], 0}.
- R6: In 10-bit mode, the read header 11110 cfgOwnAddr[9:8] 1 as a first byte gets ACK, a match pulse, dirRead=1 and matchedAddr=cfgOwnAddr, but only if a full 10-bit write match happened earlier since the last STOP. Otherwise it gets NACK.
- R7: With cfgGenCallEn=1, the first byte 8'h00 gets ACK and a match pulse with genCall=1, dirRead=0 and matchedAddr=0. With cfgGenCallEn=0 it gets NACK. The byte 8'h01 always gets NACK.
- R8: With cfgSmbusEn=1, a first byte whose bits 7:1 are 7'h08, 7'h0C or 7'h61 matches in either direction, and matchedAddr holds those 7 bits. With cfgSmbusEn=0 these bytes get NACK.
- R9: A byte whose byteSecond flag disagrees with the position the recognizer expects gets NACK and starts the ignore state.
- R10: After a match, later data bytes get no response, and matchedAddr, dirRead and genCall hold until the next match.
- R11: A STOP clears the memory of a 10-bit match, so a read header after a STOP and a new START gets NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfgOwnAddr | input | 10 | Own address (bits 6:0 used in 7-bit mode) |
| cfgTenBit | input | 1 | 1 selects 10-bit addressing |
| cfgGenCallEn | input | 1 | Enables general-call recognition |
| cfgSmbusEn | input | 1 | Enables the reserved SMBus addresses |
| startSeen | input | 1 | One-cycle pulse on START or repeated START |
| stopSeen | input | 1 | One-cycle pulse on STOP |
| byteValid | input | 1 | Strobe for a received byte |
| byteData | input | 8 | Received byte, bit 7 first on the wire |
| byteSecond | input | 1 | 0 for first byte after START, 1 for second |
| ackValid | output | 1 | A decision for the last byte is present |
| ackYes | output | 1 | 1 means ACK, 0 means NACK |
| matchPulse | output | 1 | One-cycle pulse on a completed address match |
| dirRead | output | 1 | Direction of the last match, 1 for read |
| genCall | output | 1 | The last match was a general call |
| matchedAddr | output | 10 | Address of the last match |

## Verification
The assertions take for granted that the byte engine never strobes a byte in the same cycle as a START or STOP pulse. They also assume that startSeen and stopSeen are never high together. The stimulus drives each condition pulse and each byte strobe in its own clock cycle, separated by idle cycles, and keeps the configuration fixed across each transaction. A response is expected exactly one cycle after each byte strobe. The scoreboard treats any decision it did not predict as a failure.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
  localparam int ADDR_W = 10;
  localparam int BYTE_W = 8;
  localparam int SEV_W  = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FIRST, ST_SECOND, ST_DONE, ST_IGNORE
  } recState_e;

  typedef enum logic [2:0] {
    K_NONE, K_SEVEN, K_GC, K_SMB, K_TENWR, K_TENRD
  } matchKind_e;

  // comparator results from datapath to control
  typedef struct packed {
    logic hdrHit;   // 11110 + own[9:8]
    logic rdBit;    // byte bit 0
    logic lowHit;   // byte == own[7:0]
    logic own7Hit;  // byte[7:1] == own[6:0]
    logic gcHit;    // enabled general call write
    logic smbHit;   // enabled reserved SMBus code
  } cmpFlags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       ack;
    logic       ackYes;
    logic       match;
    matchKind_e kind;
  } ctrlStrb_t;

  function automatic logic [SEV_W-1:0] smbCode(input int idx);
    case (idx)
      0:       return 7'h08;
      1:       return 7'h0C;
      default: return 7'h61;
    endcase
  endfunction
endpackage

// File: rtl/i2c_addr_dp.sv
module i2c_addr_dp
  import i2c_addr_pkg::*;
#(
  parameter int NUM_SMB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfgOwnAddr,
  input  logic              cfgGenCallEn,
  input  logic              cfgSmbusEn,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  ctrlStrb_t         strb,
  output cmpFlags_t         cmp,
  output logic              ackValid,
  output logic              ackYes,
  output logic              matchPulse,
  output logic              dirRead,
  output logic              genCall,
  output logic [ADDR_W-1:0] matchedAddr
);
  localparam int PAD_W = ADDR_W - SEV_W;

  logic [NUM_SMB-1:0] smbVec;

  for (genvar i = 0; i < NUM_SMB; i++) begin : g_smb
    assign smbVec[i] = (byteData[BYTE_W-1:1] == smbCode(i));
  end

  always_comb begin
    cmp.hdrHit  = (byteData[7:3] == 5'b11110) && (byteData[2:1] == cfgOwnAddr[9:8]);
    cmp.rdBit   = byteData[0];
    cmp.lowHit  = (byteData == cfgOwnAddr[7:0]);
    cmp.own7Hit = (byteData[BYTE_W-1:1] == cfgOwnAddr[SEV_W-1:0]);
    cmp.gcHit   = cfgGenCallEn && (byteData == '0);
    cmp.smbHit  = cfgSmbusEn && (|smbVec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ackValid    <= 1'b0;
      ackYes      <= 1'b0;
      matchPulse  <= 1'b0;
      dirRead     <= 1'b0;
      genCall     <= 1'b0;
      matchedAddr <= '0;
    end else begin
      ackValid   <= strb.ack;
      ackYes     <= strb.ack && strb.ackYes;
      matchPulse <= strb.match;
      if (strb.match) begin
        unique case (strb.kind)
          K_SEVEN, K_SMB: begin
            dirRead     <= byteData[0];
            genCall     <= 1'b0;
            matchedAddr <= {{PAD_W{1'b0}}, byteData[BYTE_W-1:1]};
          end
          K_GC: begin
            dirRead     <= 1'b0;
            genCall     <= 1'b1;
            matchedAddr <= '0;
          end
          K_TENWR: begin
            dirRead     <= 1'b0;
            genCall     <= 1'b0;
            matchedAddr <= cfgOwnAddr;
          end
          K_TENRD: begin
            dirRead     <= 1'b1;
            genCall     <= 1'b0;
            matchedAddr <= cfgOwnAddr;
          end
          default: ;
        endcase
      end
    end
  end

  // R2: a decision only ever follows a byte strobe by one cycle
  p_ack_follows_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ackValid |-> $past(byteValid));

  // R2: a match is always acknowledged
  p_match_acked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    matchPulse |-> (ackValid && ackYes));

  // R7: general-call result shape
  p_gc_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (matchPulse && genCall) |-> (matchedAddr == '0 && !dirRead));

  // R10: match results hold between matches
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !matchPulse |-> ($stable(matchedAddr) && $stable(genCall) && $stable(dirRead)));
endmodule

// File: rtl/i2c_addr_ctrl.sv
module i2c_addr_ctrl
  import i2c_addr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfgTenBit,
  input  logic      startSeen,
  input  logic      stopSeen,
  input  logic      byteValid,
  input  logic      byteSecond,
  input  cmpFlags_t cmp,
  output ctrlStrb_t strb
);
  recState_e state, stateNxt;
  logic      tenMatched, tenMatchedNxt;

  always_comb begin
    stateNxt      = state;
    tenMatchedNxt = tenMatched;
    strb          = '{ack: 1'b0, ackYes: 1'b0, match: 1'b0, kind: K_NONE};

    if (stopSeen) begin
      stateNxt      = ST_IDLE;
      tenMatchedNxt = 1'b0;
    end else if (startSeen) begin
      stateNxt = ST_FIRST;
    end else if (byteValid) begin
      unique case (state)
        ST_FIRST: begin
          strb.ack = 1'b1;
          stateNxt = ST_IGNORE;
          tenMatchedNxt = 1'b0;
          if (byteSecond) begin
            strb.ackYes = 1'b0;
          end else if (cfgTenBit && cmp.hdrHit) begin
            if (!cmp.rdBit) begin
              strb.ackYes = 1'b1;
              stateNxt    = ST_SECOND;
            end else if (tenMatched) begin
              strb.ackYes   = 1'b1;
              strb.match    = 1'b1;
              strb.kind     = K_TENRD;
              stateNxt      = ST_DONE;
              tenMatchedNxt = 1'b1;
            end
          end else if (cmp.gcHit) begin
            strb.ackYes = 1'b1;
            strb.match  = 1'b1;
            strb.kind   = K_GC;
            stateNxt    = ST_DONE;
          end else if (!cfgTenBit && cmp.own7Hit) begin
            strb.ackYes = 1'b1;
            strb.match  = 1'b1;
            strb.kind   = K_SEVEN;
            stateNxt    = ST_DONE;
          end else if (cmp.smbHit) begin
            strb.ackYes = 1'b1;
            strb.match  = 1'b1;
            strb.kind   = K_SMB;
            stateNxt    = ST_DONE;
          end
        end
        ST_SECOND: begin
          strb.ack = 1'b1;
          if (byteSecond && cmp.lowHit) begin
            strb.ackYes   = 1'b1;
            strb.match    = 1'b1;
            strb.kind     = K_TENWR;
            stateNxt      = ST_DONE;
            tenMatchedNxt = 1'b1;
          end else begin
            stateNxt      = ST_IGNORE;
            tenMatchedNxt = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tenMatched <= 1'b0;
    end else begin
      state      <= stateNxt;
      tenMatched <= tenMatchedNxt;
    end
  end

  // input assumption: a byte never coincides with a bus condition
  p_byte_not_on_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(byteValid && (startSeen || stopSeen)));

  // R3: the ignore state holds until a bus condition
  p_ignore_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE && !startSeen && !stopSeen) |=> state == ST_IGNORE);

  // R6: a 10-bit read match needs earlier 10-bit history
  p_tenrd_history_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.match && strb.kind == K_TENRD) |-> tenMatched);

  // R11: STOP wipes the 10-bit history
  p_stop_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stopSeen |=> !tenMatched);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_addr_pkg::*;
#(
  parameter int NUM_SMB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfgOwnAddr,
  input  logic              cfgTenBit,
  input  logic              cfgGenCallEn,
  input  logic              cfgSmbusEn,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              byteSecond,
  output logic              ackValid,
  output logic              ackYes,
  output logic              matchPulse,
  output logic              dirRead,
  output logic              genCall,
  output logic [ADDR_W-1:0] matchedAddr
);
  cmpFlags_t cmp;
  ctrlStrb_t strb;

  i2c_addr_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgTenBit (cfgTenBit),
    .startSeen (startSeen),
    .stopSeen  (stopSeen),
    .byteValid (byteValid),
    .byteSecond(byteSecond),
    .cmp       (cmp),
    .strb      (strb)
  );

  i2c_addr_dp #(.NUM_SMB(NUM_SMB)) i_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfgOwnAddr  (cfgOwnAddr),
    .cfgGenCallEn(cfgGenCallEn),
    .cfgSmbusEn  (cfgSmbusEn),
    .byteValid   (byteValid),
    .byteData    (byteData),
    .strb        (strb),
    .cmp         (cmp),
    .ackValid    (ackValid),
    .ackYes      (ackYes),
    .matchPulse  (matchPulse),
    .dirRead     (dirRead),
    .genCall     (genCall),
    .matchedAddr (matchedAddr)
  );
endmodule

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] cfgOwnAddr = 10'h03A;
  logic       cfgTenBit = 1'b0;
  logic       cfgGenCallEn = 1'b0;
  logic       cfgSmbusEn = 1'b0;
  logic       startSeen = 1'b0;
  logic       stopSeen = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic       byteSecond = 1'b0;
  logic       ackValid, ackYes, matchPulse, dirRead, genCall;
  logic [9:0] matchedAddr;

  int checks = 0;
  int failures = 0;

  // expected item: {ackYes, match, dir, gc, addr}
  logic [13:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  i2c_addr_match i_i2c_addr_match (
    .clk(clk), .rst_n(rst_n), .cfgOwnAddr(cfgOwnAddr), .cfgTenBit(cfgTenBit),
    .cfgGenCallEn(cfgGenCallEn), .cfgSmbusEn(cfgSmbusEn), .startSeen(startSeen),
    .stopSeen(stopSeen), .byteValid(byteValid), .byteData(byteData),
    .byteSecond(byteSecond), .ackValid(ackValid), .ackYes(ackYes),
    .matchPulse(matchPulse), .dirRead(dirRead), .genCall(genCall),
    .matchedAddr(matchedAddr)
  );

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && ackValid) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL unexpected decision: actual ack=%0b match=%0b expected none", ackYes, matchPulse);
      end else begin
        logic [13:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (ackYes !== e[13] || matchPulse !== e[12] ||
            (e[12] && (dirRead !== e[11] || genCall !== e[10] || matchedAddr !== e[9:0]))) begin
          failures++;
          $display("FAIL %s: actual ack=%0b match=%0b dir=%0b gc=%0b addr=%h expected ack=%0b match=%0b dir=%0b gc=%0b addr=%h",
                   t, ackYes, matchPulse, dirRead, genCall, matchedAddr,
                   e[13], e[12], e[11], e[10], e[9:0]);
        end
      end
    end
  end

  task automatic cond(input bit isStart);
    @(negedge clk);
    startSeen = isStart;
    stopSeen  = !isStart;
    @(negedge clk);
    startSeen = 1'b0;
    stopSeen  = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d, input bit second, input bit eAck,
                          input bit eMatch, input bit eDir, input bit eGc,
                          input logic [9:0] eAddr, input string tag);
    @(negedge clk);
    expQ.push_back({eAck, eMatch, eDir, eGc, eAddr});
    tagQ.push_back(tag);
    byteValid = 1'b1; byteData = d; byteSecond = second;
    @(negedge clk);
    byteValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic silentByte(input logic [7:0] d, input bit second, input string tag);
    @(negedge clk);
    byteValid = 1'b1; byteData = d; byteSecond = second;
    @(negedge clk);
    byteValid = 1'b0;
    checks++;
    if (ackValid !== 1'b0) begin
      failures++;
      $display("FAIL %s: actual ackValid=%0b expected 0", tag, ackValid);
    end
    @(negedge clk);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (ackValid !== 0 || ackYes !== 0 || matchPulse !== 0 || dirRead !== 0 ||
        genCall !== 0 || matchedAddr !== 10'h0) begin
      failures++;
      $display("FAIL R1: actual outputs %0b%0b%0b%0b%0b addr=%h expected all zero",
               ackValid, ackYes, matchPulse, dirRead, genCall, matchedAddr);
    end
    rst_n = 1'b1;
    silentByte(8'h74, 0, "R1 byte before START");

    // R2 7-bit match write and read
    cond(1);
    sendByte(8'h74, 0, 1, 1, 0, 0, 10'h03A, "R2 7-bit write");
    silentByte(8'h55, 0, "R10 data byte ignored");
    checks++;
    if (matchedAddr !== 10'h03A || dirRead !== 0) begin
      failures++;
      $display("FAIL R10: actual addr=%h dir=%0b expected 03a 0", matchedAddr, dirRead);
    end
    cond(1);
    sendByte(8'h75, 0, 1, 1, 1, 0, 10'h03A, "R2 7-bit read");
    cond(0);

    // R3 mismatch then ignore
    cond(1);
    sendByte(8'h76, 0, 0, 0, 0, 0, 10'h0, "R3 mismatch NACK");
    silentByte(8'h74, 0, "R3 ignored until START");

    // R7 general call
    cond(1);
    sendByte(8'h00, 0, 0, 0, 0, 0, 10'h0, "R7 gc disabled");
    cfgGenCallEn = 1'b1;
    cond(1);
    sendByte(8'h00, 0, 1, 1, 0, 1, 10'h000, "R7 gc enabled");
    cond(1);
    sendByte(8'h01, 0, 0, 0, 0, 0, 10'h0, "R7 gc read NACK");
    cond(0);

    // R8 SMBus reserved
    cond(1);
    sendByte(8'h10, 0, 0, 0, 0, 0, 10'h0, "R8 smbus disabled");
    cfgSmbusEn = 1'b1;
    cond(1);
    sendByte(8'h10, 0, 1, 1, 0, 0, 10'h008, "R8 host code");
    cond(1);
    sendByte(8'hC3, 0, 1, 1, 1, 0, 10'h061, "R8 default device code");
    cond(1);
    sendByte(8'h19, 0, 1, 1, 1, 0, 10'h00C, "R8 alert code");
    cond(0);

    // R9 position mismatch
    cond(1);
    sendByte(8'h74, 1, 0, 0, 0, 0, 10'h0, "R9 second flag on first byte");
    silentByte(8'h74, 0, "R9 ignore after");

    // 10-bit mode, own 0x2A5
    cfgTenBit = 1'b1; cfgOwnAddr = 10'h2A5;
    cond(0);
    cond(1);
    sendByte(8'hF4, 0, 1, 0, 0, 0, 10'h0, "R4 write header");
    sendByte(8'hA5, 1, 1, 1, 0, 0, 10'h2A5, "R4 low byte");
    cond(1);
    sendByte(8'hF5, 0, 1, 1, 1, 0, 10'h2A5, "R6 read after repeated START");
    silentByte(8'h12, 0, "R10 data ignored 10-bit");
    cond(0);
    cond(1);
    sendByte(8'hF5, 0, 0, 0, 0, 0, 10'h0, "R11 read after STOP");
    cond(1);
    sendByte(8'hF4, 0, 1, 0, 0, 0, 10'h0, "R5 header again");
    sendByte(8'hA4, 1, 0, 0, 0, 0, 10'h0, "R5 low mismatch");
    cond(1);
    sendByte(8'hF5, 0, 0, 0, 0, 0, 10'h0, "R6 read without history");
    cond(1);
    sendByte(8'hF6, 0, 0, 0, 0, 0, 10'h0, "R5 header high bits wrong");
    cond(1);
    sendByte(8'h4A, 0, 0, 0, 0, 0, 10'h0, "R5 7-bit byte in 10-bit mode");
    cond(1);
    sendByte(8'hF4, 0, 1, 0, 0, 0, 10'h0, "R9 header");
    sendByte(8'hA5, 0, 0, 0, 0, 0, 10'h0, "R9 low byte wrong flag");
    cond(0);

    repeat (4) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R2: actual %0d pending decisions expected 0", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule